// File: doc/BRIEF.md
# Clock-Crossing Byte Register Bridge

This block gives a processor running on a fast clock access to a bank of byte-wide registers that sit behind a register bus in a slower clock domain. The processor issues an access by writing one request word that carries the remote address, the write byte and a direction flag. The request is latched, announced to the slow domain through a toggle, and carried out there by a small bus master. Completion comes back through a second pair of toggles. Every toggle passes through a two-flop synchroniser in each direction.

Reads are posted. The processor polls a status byte until both busy bits are clear and the ready bit is set, then fetches the byte from a separate result register. The two busy bits are distinct. One covers the request while it is still crossing into the slow domain. The other covers the time from the slow side picking up the request to the completion reaching the fast side. A request issued while the bridge is busy is dropped and raises a sticky overrun flag.

Top module: `xbr_bridge`

## Requirements
- R1: After reset the status byte reads 0x00, the result register reads 0x00 and the slow-side bus request `reg_req` is low.
- R2: A write request (request word bit 16 = 1, address in bits 15:8, data in bits 7:0) produces one slow-side bus cycle with `reg_we` high and that address and data. Address, data and direction stay stable while `reg_req` is high and `reg_ack` is low, and the remote register takes the byte.
- R3: A read request (bit 16 = 0) fetches the remote byte. When the access finishes, status bit 0 (ready) becomes 1 and the result register (CPU address 2) holds the byte.
- R4: Status bit 3 is 1 from the cycle after a request is accepted until the slow domain has acknowledged picking it up.
- R5: Status bit 2 is 1 from the slow-side pickup until completion is seen on the fast side. During a long slow-side access, the status reads bit 2 = 1 and bit 3 = 0.
- R6: A request written while status bit 3 or bit 2 is set is ignored: no remote access follows and the access in flight is unchanged. Status bit 4 (overrun) is set and stays set.
- R7: Writing the status register (CPU address 1) with bit 4 = 1 clears the overrun flag.
- R8: Reading the result register clears status bit 0.
- R9: An accepted new request clears status bit 0.
- R10: `reg_req` stays high once raised until `reg_ack` is seen, and it is dropped in the cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Fast (processor) clock |
| cpu_rst_n | input | 1 | Active-low reset, fast domain |
| slow_clk | input | 1 | Slow (register bus) clock |
| slow_rst_n | input | 1 | Active-low reset, slow domain |
| cpu_sel | input | 1 | Register access strobe, one cycle per access |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 2 | 0 = request, 1 = status, 2 = result |
| cpu_wdata | input | ADDR_W+9 | Request word or status write data |
| cpu_rdata | output | 8 | Read data: status byte or result byte |
| reg_req | output | 1 | Slow-side bus request, held until acknowledged |
| reg_we | output | 1 | Slow-side bus direction, 1 = write |
| reg_addr | output | ADDR_W | Slow-side register address |
| reg_wdata | output | 8 | Slow-side write byte |
| reg_ack | input | 1 | Slow-side bus acknowledge, one slow cycle |
| reg_rdata | input | 8 | Slow-side read byte, valid with `reg_ack` |

## Verification
Directed sequences come first. A write followed by a read-back of the same address separates a lost write from a wrong read path. A slow-side access with a long acknowledge latency separates the two busy bits, because only the second should remain set. Requests issued mid-flight, and new requests issued after a completed read, show whether the overrun, drop and ready-clearing rules hold. A seeded random mix of reads and writes to random addresses with random acknowledge latencies then compares every read result against a model of the remote byte array kept in the bench.

// File: rtl/xbr_pkg.sv
package xbr_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        CPU_REQ    = 2'd0,
        CPU_STATUS = 2'd1,
        CPU_RESULT = 2'd2
    } cpu_reg_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_WAIT = 1'b1
    } bus_state_e;

    localparam int ST_READY = 0;
    localparam int ST_SLOW  = 2;
    localparam int ST_CROSS = 3;
    localparam int ST_OVR   = 4;
endpackage

// File: rtl/xbr_sync.sv
module xbr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_q, sh_d;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/xbr_cpu_side.sv
module xbr_cpu_side
    import xbr_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int REQ_W = ADDR_W + BYTE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [REQ_W-1:0]  wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              req_tgl,
    output logic              hold_we,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [BYTE_W-1:0] hold_wdata,
    input  logic              start_s,
    input  logic              done_s,
    input  logic [BYTE_W-1:0] slow_rdata
);
    typedef struct packed {
        logic              req_tgl;
        logic              done_seen;
        logic              ready;
        logic              ovr;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] wbyte;
        logic [BYTE_W-1:0] result;
    } cpu_st_t;

    cpu_st_t st_q, st_d;
    logic busy_cross, busy_slow, busy;
    logic req_hit, stat_wr, res_rd, done_evt;

    always_comb begin
        busy_cross = st_q.req_tgl != start_s;
        busy_slow  = start_s != st_q.done_seen;
        busy       = busy_cross || busy_slow;
        req_hit    = sel && we  && (addr == CPU_REQ);
        stat_wr    = sel && we  && (addr == CPU_STATUS);
        res_rd     = sel && !we && (addr == CPU_RESULT);
        done_evt   = done_s != st_q.done_seen;

        st_d = st_q;
        if (stat_wr && wdata[ST_OVR]) st_d.ovr = 1'b0;
        if (res_rd) st_d.ready = 1'b0;
        if (req_hit) begin
            if (busy) begin
                st_d.ovr = 1'b1;
            end else begin
                st_d.req_tgl = ~st_q.req_tgl;
                st_d.wbyte   = wdata[BYTE_W-1:0];
                st_d.addr    = wdata[BYTE_W +: ADDR_W];
                st_d.we      = wdata[BYTE_W+ADDR_W];
                st_d.ready   = 1'b0;
            end
        end
        if (done_evt) begin
            st_d.done_seen = done_s;
            if (!st_q.we) begin
                st_d.ready  = 1'b1;
                st_d.result = slow_rdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (addr == CPU_RESULT) begin
            rdata = st_q.result;
        end else if (addr == CPU_STATUS) begin
            rdata[ST_READY] = st_q.ready;
            rdata[ST_SLOW]  = busy_slow;
            rdata[ST_CROSS] = busy_cross;
            rdata[ST_OVR]   = st_q.ovr;
        end
    end

    assign req_tgl    = st_q.req_tgl;
    assign hold_we    = st_q.we;
    assign hold_addr  = st_q.addr;
    assign hold_wdata = st_q.wbyte;

    // R6
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_hit && busy) |=> (st_q.ovr && $stable(req_tgl)));
    // R4
    cross_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_hit && !busy) |=> busy_cross);
    // R8
    result_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_rd && !busy) |=> !st_q.ready);
    // R3
    ready_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ready) |-> !busy);
endmodule

// File: rtl/xbr_slow_side.sv
module xbr_slow_side
    import xbr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_s,
    input  logic [ADDR_W-1:0] hold_addr,
    output logic              start_tgl,
    output logic              done_tgl,
    output logic [BYTE_W-1:0] result,
    output logic              bus_req,
    input  logic              bus_ack,
    input  logic [BYTE_W-1:0] bus_rdata
);
    typedef struct packed {
        bus_state_e        state;
        logic              seen;
        logic              start_tgl;
        logic              done_tgl;
        logic              bus_req;
        logic [BYTE_W-1:0] rd;
    } slow_st_t;

    slow_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        case (st_q.state)
            BUS_IDLE: begin
                if (req_s != st_q.seen) begin
                    st_d.seen      = req_s;
                    st_d.start_tgl = ~st_q.start_tgl;
                    st_d.bus_req   = 1'b1;
                    st_d.state     = BUS_WAIT;
                end
            end
            default: begin
                if (bus_ack) begin
                    st_d.bus_req  = 1'b0;
                    st_d.rd       = bus_rdata;
                    st_d.done_tgl = ~st_q.done_tgl;
                    st_d.state    = BUS_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: BUS_IDLE, default: '0};
        else        st_q <= st_d;
    end

    assign start_tgl = st_q.start_tgl;
    assign done_tgl  = st_q.done_tgl;
    assign result    = st_q.rd;
    assign bus_req   = st_q.bus_req;

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> bus_req);
    // R10
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack) |=> !bus_req);
    // R2
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> $stable(hold_addr));
endmodule

// File: rtl/xbr_bridge.sv
module xbr_bridge
    import xbr_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int REQ_W = ADDR_W + BYTE_W + 1
) (
    input  logic              cpu_clk,
    input  logic              cpu_rst_n,
    input  logic              slow_clk,
    input  logic              slow_rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_addr,
    input  logic [REQ_W-1:0]  cpu_wdata,
    output logic [BYTE_W-1:0] cpu_rdata,
    output logic              reg_req,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    input  logic              reg_ack,
    input  logic [BYTE_W-1:0] reg_rdata
);
    logic req_tgl, req_s;
    logic start_tgl, start_s;
    logic done_tgl, done_s;
    logic [BYTE_W-1:0] slow_result;

    xbr_cpu_side #(.ADDR_W(ADDR_W)) cpu_i (
        .clk(cpu_clk), .rst_n(cpu_rst_n),
        .sel(cpu_sel), .we(cpu_we), .addr(cpu_addr), .wdata(cpu_wdata),
        .rdata(cpu_rdata),
        .req_tgl(req_tgl), .hold_we(reg_we), .hold_addr(reg_addr),
        .hold_wdata(reg_wdata),
        .start_s(start_s), .done_s(done_s), .slow_rdata(slow_result)
    );

    xbr_sync #(.STAGES(SYNC_STAGES)) req_sync_i (
        .clk(slow_clk), .rst_n(slow_rst_n), .din(req_tgl), .dout(req_s)
    );
    xbr_sync #(.STAGES(SYNC_STAGES)) start_sync_i (
        .clk(cpu_clk), .rst_n(cpu_rst_n), .din(start_tgl), .dout(start_s)
    );
    xbr_sync #(.STAGES(SYNC_STAGES)) done_sync_i (
        .clk(cpu_clk), .rst_n(cpu_rst_n), .din(done_tgl), .dout(done_s)
    );

    xbr_slow_side #(.ADDR_W(ADDR_W)) slow_i (
        .clk(slow_clk), .rst_n(slow_rst_n),
        .req_s(req_s), .hold_addr(reg_addr),
        .start_tgl(start_tgl), .done_tgl(done_tgl), .result(slow_result),
        .bus_req(reg_req), .bus_ack(reg_ack), .bus_rdata(reg_rdata)
    );
endmodule

// File: tb/xbr_bridge_tb.sv
module xbr_bridge_tb_top;
    localparam int AW = 8;
    localparam int RW = AW + 9;

    logic cpu_clk = 1'b0, slow_clk = 1'b0, rst_n = 1'b0;
    logic cpu_sel = 1'b0, cpu_we = 1'b0;
    logic [1:0] cpu_addr = 2'd0;
    logic [RW-1:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic reg_req, reg_we, reg_ack;
    logic [AW-1:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;

    always #2 cpu_clk = ~cpu_clk;
    always #7 slow_clk = ~slow_clk;

    xbr_bridge #(.ADDR_W(AW)) dut_i (
        .cpu_clk(cpu_clk), .cpu_rst_n(rst_n), .slow_clk(slow_clk), .slow_rst_n(rst_n),
        .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata)
    );

    // remote register bank model
    logic [7:0] mem [256];
    logic [7:0] shadow [256];
    int lat = 0, cnt = 0, wr_count = 0;
    logic ack_r = 1'b0;
    logic [7:0] rd_r = '0;
    assign reg_ack = ack_r;
    assign reg_rdata = rd_r;

    always @(posedge slow_clk) begin
        if (!rst_n) begin
            ack_r <= 1'b0; cnt <= 0;
        end else if (ack_r) begin
            ack_r <= 1'b0; cnt <= 0;
        end else if (reg_req) begin
            if (cnt >= lat) begin
                ack_r <= 1'b1;
                rd_r  <= mem[reg_addr];
                if (reg_we) begin
                    mem[reg_addr] <= reg_wdata;
                    wr_count <= wr_count + 1;
                end
            end else begin
                cnt <= cnt + 1;
            end
        end
    end

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [RW-1:0] req_word(input bit wr, input logic [7:0] a,
                                               input logic [7:0] d);
        return {wr, a, d};
    endfunction

    task automatic cpu_write(input logic [1:0] a, input logic [RW-1:0] d);
        @(negedge cpu_clk);
        cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge cpu_clk);
        cpu_sel = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge cpu_clk);
        cpu_sel = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        #1 v = cpu_rdata;
        @(negedge cpu_clk);
        cpu_sel = 1'b0;
    endtask

    task automatic peek_status(output logic [7:0] v);
        cpu_sel = 1'b0; cpu_addr = 2'd1;
        #1 v = cpu_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 3000; i++) begin
            cpu_read(2'd1, s);
            if ((s & 8'h0C) == 0) break;
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, a, d;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'($urandom);
            shadow[i] = mem[i];
        end
        repeat (5) @(posedge slow_clk);
        rst_n = 1'b1;
        repeat (3) @(posedge cpu_clk);

        // R1 reset state
        cpu_read(2'd1, v); check("R1 status", v, 8'h00);
        cpu_read(2'd2, v); check("R1 result", v, 8'h00);
        check("R1 reg_req", reg_req, 0);

        // R2 directed write then read-back, R4 crossing bit
        cpu_write(2'd0, req_word(1, 8'h3C, 8'hA5)); shadow[8'h3C] = 8'hA5;
        peek_status(v); check("R4 cross bit after issue", v & 8'h08, 8'h08);
        wait_idle();
        check("R2 remote write", mem[8'h3C], 8'hA5);
        cpu_read(2'd1, v); check("R2 write leaves ready low", v, 8'h00);
        cpu_write(2'd0, req_word(0, 8'h3C, 8'h00));
        wait_idle();
        cpu_read(2'd1, v); check("R3 ready after read", v, 8'h01);
        cpu_read(2'd2, v); check("R3 result", v, 8'hA5);
        cpu_read(2'd1, v); check("R8 ready cleared by result read", v & 8'h01, 0);

        // R5 long slow access
        lat = 25;
        cpu_write(2'd0, req_word(0, 8'h07, 8'h00));
        #150;
        cpu_read(2'd1, v); check("R5 slow busy only", v, 8'h04);
        // R6 request while busy
        cpu_write(2'd0, req_word(1, 8'h09, 8'h5A));
        wait_idle();
        cpu_read(2'd1, v); check("R6 overrun with ready", v, 8'h11);
        check("R6 dropped write", mem[8'h09], shadow[8'h09]);
        cpu_read(2'd2, v); check("R6 in-flight read intact", v, shadow[8'h07]);
        cpu_read(2'd1, v); check("R6 overrun sticky", v, 8'h10);
        cpu_write(2'd1, 17'h10);
        cpu_read(2'd1, v); check("R7 overrun cleared", v, 8'h00);
        lat = 0;

        // R9 new request clears ready
        cpu_write(2'd0, req_word(0, 8'h11, 8'h00));
        wait_idle();
        cpu_read(2'd1, v); check("R9 ready before new req", v, 8'h01);
        cpu_write(2'd0, req_word(1, 8'h12, 8'h66)); shadow[8'h12] = 8'h66;
        peek_status(v); check("R9 ready cleared by new req", v & 8'h01, 0);
        wait_idle();

        // random mix
        for (int n = 0; n < 60; n++) begin
            a = 8'($urandom);
            d = 8'($urandom);
            lat = int'($urandom % 6);
            if ($urandom % 2) begin
                cpu_write(2'd0, req_word(1, a, d)); shadow[a] = d;
                wait_idle();
                check("R2 random write", mem[a], shadow[a]);
            end else begin
                cpu_write(2'd0, req_word(0, a, 8'h00));
                wait_idle();
                cpu_read(2'd1, v); check("R3 random ready", v, 8'h01);
                cpu_read(2'd2, v); check("R3 random read", v, shadow[a]);
            end
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule